// File: doc/BRIEF.md
# Edge Event ASCII Line Transmitter

This block turns single-channel edge events, taken one at a time from an upstream queue, into fixed-length printable text lines on an asynchronous serial output. Each event carries a channel number from 0 to 7, an edge direction and a 20-bit capture count. The block prints one header character that packs the channel and the edge direction together. Five uppercase hexadecimal characters for the count follow, and a carriage return ends the line. Every line is therefore seven bytes long and holds no binary data, so a host can read it on a plain terminal.

The serial side is a built-in transmitter that sends each byte as one start bit, eight data bits with the least significant bit first, and one stop bit. Each bit lasts a fixed number of clock cycles, set by a parameter; a 50 MHz clock with a divisor near 1302 gives a rate close to 38.4 kbit/s. The line has no flow control. Events enter through a ready/valid handshake. An event is taken only when the transmitter can begin it without a gap, and all of its fields are captured at that moment.

Top module: `hex_event_uart_tx`

## Requirements
- R1: After reset the serial line is high and the event input reports ready.
- R2: The first byte of a line is the hex character of the 4-bit value {falling, channel}: '0' to '7' (0x30 to 0x37) for a rising edge on channels 0 to 7, and '8' to 'F' for a falling edge on channels 0 to 7.
- R3: Bytes 2 to 6 are the hex characters of the 20-bit count, one character per 4-bit digit, most significant digit first.
- R4: Digit values 0 to 9 are sent as 0x30 to 0x39, and values 10 to 15 as uppercase 0x41 to 0x46.
- R5: Byte 7 of each line is a carriage return (0x0D), so each event produces exactly seven bytes.
- R6: Each byte is framed as one low start bit, eight data bits with the least significant bit first, and one high stop bit, and each bit lasts BAUD_DIV clock cycles. The line is high when idle, and a start bit begins in the cycle after an event is accepted.
- R7: Ready is high only when no line is in progress, or in the last cycle of the final stop bit. The event fields are captured at acceptance, so later changes on the inputs do not alter the line being sent.
- R8: When the next event is already waiting, its start bit follows the previous line's final stop bit directly, and accepted events are then exactly 70*BAUD_DIV cycles apart.
- R9: The serial line changes level only at bit boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | An event is offered |
| evtReady | output | 1 | The event is accepted on this cycle's rising edge if valid |
| evtChan | input | 3 | Channel number of the event |
| evtFall | input | 1 | 1 for a falling edge, 0 for a rising edge |
| evtStamp | input | 20 | Capture count of the event |
| txLine | output | 1 | Serial output, idle high |

## Verification
The start bit must appear in the first cycle after the accepting edge. Each later bit is due exactly BAUD_DIV cycles after the one before it, a full line takes 70*BAUD_DIV cycles, and ready must rise in the last of those cycles. The bench holds an expected per-cycle level queue that is filled at each observed acceptance. It compares the line and ready against this queue at every falling clock edge, half a cycle away from the edge that moves them. A behavioural receiver samples each bit at its centre and checks the decoded bytes against the expected characters. The cycle counts between back-to-back acceptances are compared with the line length.

// File: rtl/evtser_pkg.sv
package evtser_pkg;
  localparam int CHAN_W     = 3;
  localparam int STAMP_W    = 20;
  localparam int NIB_W      = 4;
  localparam int DIGITS     = STAMP_W / NIB_W;
  localparam int REC_LEN    = DIGITS + 2;
  localparam int SEL_W      = $clog2(REC_LEN);
  localparam int FRAME_BITS = 10;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  // strobes from control to datapath
  typedef struct packed {
    logic             load;      // capture event and start byte 0
    logic             shift;     // advance to next bit of frame
    logic             nextByte;  // load frame of byte byteSel
    logic [SEL_W-1:0] byteSel;   // which byte of the line to frame
  } dpCtrl_t;
endpackage

// File: rtl/evtser_ctrl.sv
module evtser_ctrl
  import evtser_pkg::*;
#(
  parameter int BAUD_DIV = 1302
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    evtValid,
  output logic    evtReady,
  output logic    busy,
  output dpCtrl_t strobe
);
  localparam int CNT_W = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;

  logic [CNT_W-1:0] baudCnt;
  logic [BIT_W-1:0] bitIdx;
  logic [SEL_W-1:0] byteIdx;
  logic bitEnd, lastBit, lastByte, lastTick, accept;

  assign bitEnd   = (baudCnt == CNT_W'(BAUD_DIV - 1));
  assign lastBit  = (bitIdx == BIT_W'(FRAME_BITS - 1));
  assign lastByte = (byteIdx == SEL_W'(REC_LEN - 1));
  assign lastTick = busy && bitEnd && lastBit && lastByte;
  assign evtReady = !busy || lastTick;
  assign accept   = evtValid && evtReady;

  always_comb begin
    strobe.load     = accept;
    strobe.shift    = busy && bitEnd && !lastBit;
    strobe.nextByte = busy && bitEnd && lastBit && !lastByte;
    strobe.byteSel  = accept ? '0 : byteIdx + SEL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      baudCnt <= '0;
      bitIdx  <= '0;
      byteIdx <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      baudCnt <= '0;
      bitIdx  <= '0;
      byteIdx <= '0;
    end else if (busy) begin
      if (bitEnd) begin
        baudCnt <= '0;
        if (!lastBit) begin
          bitIdx <= bitIdx + BIT_W'(1);
        end else if (!lastByte) begin
          bitIdx  <= '0;
          byteIdx <= byteIdx + SEL_W'(1);
        end else begin
          busy    <= 1'b0;
          bitIdx  <= '0;
          byteIdx <= '0;
        end
      end else begin
        baudCnt <= baudCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/evtser_dp.sv
module evtser_dp
  import evtser_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            strobe,
  input  logic [CHAN_W-1:0]  evtChan,
  input  logic               evtFall,
  input  logic [STAMP_W-1:0] evtStamp,
  output logic               txLine
);
  logic [NIB_W-1:0]      leadQ, leadSrc;
  logic [STAMP_W-1:0]    stampQ, stampSrc;
  logic [FRAME_BITS-1:0] frameQ;
  logic [NIB_W-1:0]      digit [DIGITS];
  logic [SEL_W-1:0]      digIdx;
  logic [7:0]            charOut;

  function automatic logic [7:0] hexChar(input logic [NIB_W-1:0] n);
    return (n < NIB_W'(10)) ? (8'h30 + 8'(n)) : (8'h37 + 8'(n));
  endfunction

  // fresh inputs feed byte 0 in the capture cycle
  assign leadSrc  = strobe.load ? {evtFall, evtChan} : leadQ;
  assign stampSrc = strobe.load ? evtStamp : stampQ;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign digit[g] = stampSrc[STAMP_W-1-g*NIB_W -: NIB_W];
  end

  assign digIdx = strobe.byteSel - SEL_W'(1);

  always_comb begin
    if (strobe.byteSel == '0)
      charOut = hexChar(leadSrc);
    else if (strobe.byteSel <= SEL_W'(DIGITS))
      charOut = hexChar(digit[digIdx]);
    else
      charOut = 8'h0D;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leadQ  <= '0;
      stampQ <= '0;
      frameQ <= '1;
    end else begin
      if (strobe.load) begin
        leadQ  <= {evtFall, evtChan};
        stampQ <= evtStamp;
      end
      if (strobe.load || strobe.nextByte)
        frameQ <= {1'b1, charOut, 1'b0};
      else if (strobe.shift)
        frameQ <= {1'b1, frameQ[FRAME_BITS-1:1]};
    end
  end

  assign txLine = frameQ[0];
endmodule

// File: rtl/hex_event_uart_tx.sv
module hex_event_uart_tx
  import evtser_pkg::*;
#(
  parameter int BAUD_DIV = 1302
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evtValid,
  output logic               evtReady,
  input  logic [CHAN_W-1:0]  evtChan,
  input  logic               evtFall,
  input  logic [STAMP_W-1:0] evtStamp,
  output logic               txLine
);
  dpCtrl_t strobe;
  logic    busy;

  evtser_ctrl #(.BAUD_DIV(BAUD_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid),
    .evtReady(evtReady), .busy(busy), .strobe(strobe)
  );

  evtser_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evtChan(evtChan),
    .evtFall(evtFall), .evtStamp(evtStamp), .txLine(txLine)
  );
endmodule

// File: rtl/evtser_chk.sv
module evtser_chk
  import evtser_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    evtValid,
  input logic    evtReady,
  input logic    txLine,
  input logic    busy,
  input dpCtrl_t strobe
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine); // R6
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtReady) |=> !txLine); // R6
  AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.shift || strobe.nextByte) |=> $stable(txLine)); // R9
  AST_READY_AT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && evtReady) |-> txLine); // R7
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && evtReady && evtValid) |=> (busy && !txLine)); // R8
endmodule

bind hex_event_uart_tx evtser_chk u_chk (
  .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtReady(evtReady),
  .txLine(txLine), .busy(busy), .strobe(strobe)
);

// File: tb/test_hex_event_uart_tx.sv
module test_hex_event_uart_tx;
  localparam int DIV     = 8;
  localparam int REC_CYC = 7 * 10 * DIV;

  logic clk = 0, rstN = 0, evtValid = 0, evtFall = 0;
  logic [2:0]  evtChan = 0;
  logic [19:0] evtStamp = 0;
  logic evtReady, txLine;

  hex_event_uart_tx #(.BAUD_DIV(DIV)) i_hex_event_uart_tx (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtReady(evtReady),
    .evtChan(evtChan), .evtFall(evtFall), .evtStamp(evtStamp), .txLine(txLine)
  );

  always #10 clk = ~clk;

  int nChk = 0, nFail = 0, cyc = 0;
  bit done = 0, accFlag = 0;
  bit expLine[$];
  logic [7:0] expByte[$];
  int accCyc[$];

  function automatic logic [7:0] hexc(int n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  function automatic logic [7:0] recByte(int pos, logic [2:0] ch, logic f, logic [19:0] st);
    if (pos == 0) return hexc({28'd0, f, ch});
    if (pos <= 5) return hexc(int'((st >> (4 * (5 - pos))) & 20'hF));
    return 8'h0D;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model and receiver, sampled at falling edges
  bit eLvl, rxBusy = 0;
  int rxT = 0, rxPos = 0, k;
  logic [7:0] rxByte, eb;
  always @(negedge clk) begin
    if (rstN && !done) begin
      cyc++;
      eLvl = (expLine.size() != 0) ? expLine.pop_front() : 1'b1;
      check(txLine === eLvl, "R6 R9", "line level", int'(txLine), int'(eLvl));
      check(evtReady === (expLine.size() == 0), "R7", "ready",
            int'(evtReady), int'(expLine.size() == 0));
      if (evtValid && evtReady) begin
        accFlag = 1;
        accCyc.push_back(cyc);
        for (int p = 0; p < 7; p++) begin
          eb = recByte(p, evtChan, evtFall, evtStamp);
          expByte.push_back(eb);
          for (int b = 0; b < 10; b++)
            for (int d = 0; d < DIV; d++)
              expLine.push_back(b == 0 ? 1'b0 : (b == 9 ? 1'b1 : eb[b-1]));
        end
      end
      if (!rxBusy) begin
        if (txLine == 1'b0) begin rxBusy = 1; rxT = 0; end
      end else begin
        rxT++;
        if (rxT % DIV == DIV / 2) begin
          k = rxT / DIV;
          if (k >= 1 && k <= 8) rxByte[k-1] = txLine;
          else if (k == 9) begin
            check(txLine === 1'b1, "R6", "stop bit", int'(txLine), 1);
            eb = (expByte.size() != 0) ? expByte.pop_front() : 8'hxx;
            if (rxPos == 0)      check(rxByte === eb, "R2", "header char", rxByte, eb);
            else if (rxPos == 6) check(rxByte === eb, "R5", "terminator", rxByte, eb);
            else                 check(rxByte === eb, "R3 R4", "count digit", rxByte, eb);
            rxPos = (rxPos + 1) % 7;
            rxBusy = 0;
          end
        end
      end
    end
  end

  task automatic send(logic [2:0] c, logic f, logic [19:0] s);
    evtChan = c; evtFall = f; evtStamp = s; evtValid = 1;
    accFlag = 0;
    do begin @(posedge clk); #1; end while (!accFlag);
    accFlag = 0;
    // scramble the inputs after capture; the line must not follow (R7)
    evtValid = 0; evtChan = ~c; evtFall = ~f; evtStamp = ~s;
  endtask

  task automatic drain();
    while (expLine.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic finish();
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk); #1;
    check(txLine === 1'b1, "R1", "idle line after reset", int'(txLine), 1);
    check(evtReady === 1'b1, "R1", "ready after reset", int'(evtReady), 1);
    @(posedge clk); #1;
    send(3'd0, 1'b0, 20'h00000); drain();
    send(3'd7, 1'b1, 20'hFFFFF); drain();
    // back-to-back group (R8)
    send(3'd3, 1'b0, 20'hA5C3E);
    send(3'd5, 1'b1, 20'h1B2D4);
    send(3'd2, 1'b0, 20'h9ABCD);
    drain();
    check(accCyc[3] - accCyc[2] == REC_CYC, "R8", "gap 1", accCyc[3] - accCyc[2], REC_CYC);
    check(accCyc[4] - accCyc[3] == REC_CYC, "R8", "gap 2", accCyc[4] - accCyc[3], REC_CYC);
    send(3'd6, 1'b1, 20'h0F0F0); drain();
    send(3'd4, 1'b0, 20'h6E18F); drain();
    check(expByte.size() == 0, "R5", "bytes left over", expByte.size(), 0);
    check(rxPos == 0, "R5", "line length alignment", rxPos, 0);
    finish();
  end

  initial begin
    #(200000 * 20);
    nChk++; nFail++;
    $display("FAIL R6 watchdog expired: actual %0d expected %0d cycles max", cyc, 200000);
    finish();
  end
endmodule